// File: doc/BRIEF.md
# Video Input Start Gating Controller

This block holds the control registers and start-up sequencing for a clocked video receiver. Software programs a control word and two lock-target words through a small word-addressed register port. The block compares the targets with the format measurements that a separate measurement stage reports. It decides when the receiver may forward video downstream, and it raises a run enable only on a start-of-frame pulse, so that no frame is cut part-way. After reset the receiver is stopped. Measurement and input acceptance carry on upstream whether or not the block is enabled.

The control word also carries enables for neighbouring logic: sync polarity auto-detection, frame padding, and a minimum frame count for interlace detection. The block drives these out unchanged. A status word reports whether forwarding is running. If both lock-target words are zero, the resolution check is skipped and forwarding starts at the first frame boundary after the master enable is set.

Top module: `vin_start_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no writes made, `run_en` is 0, every register reads 0, and `pol_auto_en`, `pad_en`, `ilace_detect_en` and `ilace_min_frames` are 0.
- R2: Writes to byte offsets 0x00 (control), 0x08 (target A) and 0x0C (target B) store all 32 bits. A read of the same offset returns the stored value in the same cycle the address is presented.
- R3: `pad_en` follows control bit 3 and `pol_auto_en` follows control bit 4. `ilace_min_frames` follows control bits 23:16, and `ilace_detect_en` is 1 exactly when those bits are nonzero.
- R4: A write to the status offset 0x04 changes no register and no output.
- R5: When targets A and B are both zero and control bit 0 is 1, `run_en` becomes 1 on the first start-of-frame, whatever the measured values are.
- R6: When either target is nonzero, all four fields must match before forwarding can start. Target A bits 31:16 must equal `meas_active_lines`, target A bits 15:0 must equal `meas_total_lines`, target B bits 31:16 must equal `meas_frames`, and target B bits 15:0 must equal `meas_out_lines`. A zero field is compared like any other field.
- R7: `run_en` changes only at a clock edge where `sof` is 1. At that edge it takes the value of the start condition, which is the master enable AND the match result from R5/R6.
- R8: If the master enable is cleared or the match is lost while running, `run_en` falls at the next start-of-frame and not before.
- R9: Reading status returns `run_en` in bit 4 and zero in all other bits.
- R10: With control bit 0 at 0, `run_en` stays 0 even when all targets match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| meas_active_lines | input | 16 | Measured active line count |
| meas_total_lines | input | 16 | Measured total line count |
| meas_frames | input | 16 | Measured frame count |
| meas_out_lines | input | 16 | Measured output line count |
| sof | input | 1 | Start-of-frame pulse, one cycle |
| run_en | output | 1 | Video forwarding enable, frame aligned |
| pol_auto_en | output | 1 | Sync polarity auto-detection enable |
| pad_en | output | 1 | Frame padding enable |
| ilace_detect_en | output | 1 | Interlace auto-detection enable |
| ilace_min_frames | output | 8 | Minimum consecutive field frames for interlace |

## Verification
The main table first runs the all-zero bypass with measurements that would fail any comparison. This shows that the check really is skipped. It then gives a full match and four cases that each break exactly one of the four fields, so that each comparison is seen to work on its own. Further rows cover a match with the master enable off, a single nonzero target whose zero fields must still be matched, and running-to-stopped transitions. Before each start-of-frame pulse the bench checks that `run_en` still holds its earlier value. This separates frame-aligned gating from gating that reacts straight away.

// File: rtl/vin_start_pkg.sv
package vin_start_pkg;
  localparam int DATA_W   = 32;
  localparam int FIELD_W  = DATA_W / 2;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int ADDR_W   = IDX_W + 2;
  localparam int NUM_FLD  = 4;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_PAD_BIT   = 3;
  localparam int CTRL_POL_BIT   = 4;
  localparam int CTRL_ILACE_LSB = 16;
  localparam int ILACE_W        = 8;
  localparam int STAT_RUN_BIT   = 4;

  typedef enum logic [IDX_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TGTA = 2'd2,
    REG_TGTB = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/vin_regs.sv
module vin_regs
  import vin_start_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              run,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] tgta_q,
  output logic [DATA_W-1:0] tgtb_q
);
  logic             aligned;
  reg_idx_e         idx;
  logic             ctrl_we, tgta_we, tgtb_we;
  logic [DATA_W-1:0] ctrl_d, tgta_d, tgtb_d, stat_word;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign idx     = reg_idx_e'(reg_addr[ADDR_W-1:2]);
  assign ctrl_we = reg_wr && aligned && (idx == REG_CTRL);
  assign tgta_we = reg_wr && aligned && (idx == REG_TGTA);
  assign tgtb_we = reg_wr && aligned && (idx == REG_TGTB);

  always_comb begin
    ctrl_d = ctrl_q;
    tgta_d = tgta_q;
    tgtb_d = tgtb_q;
    if (ctrl_we) ctrl_d = reg_wdata;
    if (tgta_we) tgta_d = reg_wdata;
    if (tgtb_we) tgtb_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tgta_q <= '0;
      tgtb_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      tgta_q <= tgta_d;
      tgtb_q <= tgtb_d;
    end
  end

  always_comb begin
    stat_word               = '0;
    stat_word[STAT_RUN_BIT] = run;
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (idx)
        REG_CTRL: reg_rdata = ctrl_q;
        REG_STAT: reg_rdata = stat_word;
        REG_TGTA: reg_rdata = tgta_q;
        REG_TGTB: reg_rdata = tgtb_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  // R4: status offset is read-only
  p_status_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(4)) |=>
      ($stable(ctrl_q) && $stable(tgta_q) && $stable(tgtb_q)));

  // R2: a write lands in the control register
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0)) |=> (ctrl_q == $past(reg_wdata)));
endmodule

// File: rtl/vin_lock_cmp.sv
module vin_lock_cmp
  import vin_start_pkg::*;
(
  input  logic [DATA_W-1:0]  tgta,
  input  logic [DATA_W-1:0]  tgtb,
  input  logic [FIELD_W-1:0] meas_active_lines,
  input  logic [FIELD_W-1:0] meas_total_lines,
  input  logic [FIELD_W-1:0] meas_frames,
  input  logic [FIELD_W-1:0] meas_out_lines,
  output logic               match
);
  logic [NUM_FLD-1:0][FIELD_W-1:0] exp_f;
  logic [NUM_FLD-1:0][FIELD_W-1:0] got_f;
  logic [NUM_FLD-1:0]              fld_eq;
  logic                            bypass;

  assign exp_f[0] = tgta[DATA_W-1:FIELD_W];
  assign exp_f[1] = tgta[FIELD_W-1:0];
  assign exp_f[2] = tgtb[DATA_W-1:FIELD_W];
  assign exp_f[3] = tgtb[FIELD_W-1:0];
  assign got_f[0] = meas_active_lines;
  assign got_f[1] = meas_total_lines;
  assign got_f[2] = meas_frames;
  assign got_f[3] = meas_out_lines;

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    assign fld_eq[i] = (exp_f[i] == got_f[i]);
  end

  assign bypass = (tgta == '0) && (tgtb == '0);
  assign match  = bypass || (&fld_eq);
endmodule

// File: rtl/vin_start_seq.sv
module vin_start_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic match,
  input  logic sof,
  output logic run
);
  logic run_q, run_d, ready;

  assign ready = enable && match;

  always_comb begin
    run_d = run_q;
    if (sof) run_d = ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign run = run_q;

  // R7: no change away from a frame boundary
  p_hold_mid_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(run_q));

  // R8: a dropped enable stops at the boundary
  p_stop_on_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !enable) |=> !run_q);

  // R10: never start without the master enable
  p_need_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(enable));
endmodule

// File: rtl/vin_start_ctrl.sv
module vin_start_ctrl
  import vin_start_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [FIELD_W-1:0]  meas_active_lines,
  input  logic [FIELD_W-1:0]  meas_total_lines,
  input  logic [FIELD_W-1:0]  meas_frames,
  input  logic [FIELD_W-1:0]  meas_out_lines,
  input  logic                sof,
  output logic                run_en,
  output logic                pol_auto_en,
  output logic                pad_en,
  output logic                ilace_detect_en,
  output logic [ILACE_W-1:0]  ilace_min_frames
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [DATA_W-1:0] ctrl_q, tgta_q, tgtb_q;
  logic              match, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  vin_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .run       (run),
    .reg_rdata (reg_rdata),
    .ctrl_q    (ctrl_q),
    .tgta_q    (tgta_q),
    .tgtb_q    (tgtb_q)
  );

  vin_lock_cmp u_cmp (
    .tgta              (tgta_q),
    .tgtb              (tgtb_q),
    .meas_active_lines (meas_active_lines),
    .meas_total_lines  (meas_total_lines),
    .meas_frames       (meas_frames),
    .meas_out_lines    (meas_out_lines),
    .match             (match)
  );

  vin_start_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .enable (ctrl_q[CTRL_EN_BIT]),
    .match  (match),
    .sof    (sof),
    .run    (run)
  );

  assign run_en           = run;
  assign pol_auto_en      = ctrl_q[CTRL_POL_BIT];
  assign pad_en           = ctrl_q[CTRL_PAD_BIT];
  assign ilace_min_frames = ctrl_q[CTRL_ILACE_LSB +: ILACE_W];
  assign ilace_detect_en  = (ilace_min_frames != '0);

  // R5: zero targets start on the boundary regardless of measurements
  p_bypass_start_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sof && ctrl_q[CTRL_EN_BIT] && tgta_q == '0 && tgtb_q == '0) |=> run_en);

  // R6: an active-line mismatch blocks start when targets are set
  p_active_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sof && (tgta_q != '0 || tgtb_q != '0) &&
     tgta_q[DATA_W-1:FIELD_W] != meas_active_lines) |=> !run_en);
endmodule

// File: tb/vin_start_ctrl_tb.sv
module vin_start_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] m_act, m_tot, m_frm, m_lin;
  logic        sof;
  logic        run_en, pol_auto_en, pad_en, ilace_detect_en;
  logic [7:0]  ilace_min_frames;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  vin_start_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .meas_active_lines(m_act), .meas_total_lines(m_tot),
    .meas_frames(m_frm), .meas_out_lines(m_lin), .sof(sof),
    .run_en(run_en), .pol_auto_en(pol_auto_en), .pad_en(pad_en),
    .ilace_detect_en(ilace_detect_en), .ilace_min_frames(ilace_min_frames)
  );

  typedef struct packed {
    logic [31:0] tgta;
    logic [31:0] tgtb;
    logic [15:0] act;
    logic [15:0] tot;
    logic [15:0] frm;
    logic [15:0] lin;
    logic        en;
    logic        exp_run;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'h0, 32'h0, 16'd1, 16'd2, 16'd3, 16'd4, 1'b1, 1'b1},
    '{32'h0438_0465, 32'h0005_0438, 16'd1080, 16'd1125, 16'd5, 16'd1080, 1'b1, 1'b1},
    '{32'h0438_0465, 32'h0005_0438, 16'd720,  16'd1125, 16'd5, 16'd1080, 1'b1, 1'b0},
    '{32'h0438_0465, 32'h0005_0438, 16'd1080, 16'd1124, 16'd5, 16'd1080, 1'b1, 1'b0},
    '{32'h0438_0465, 32'h0005_0438, 16'd1080, 16'd1125, 16'd6, 16'd1080, 1'b1, 1'b0},
    '{32'h0438_0465, 32'h0005_0438, 16'd1080, 16'd1125, 16'd5, 16'd1079, 1'b1, 1'b0},
    '{32'h0438_0465, 32'h0005_0438, 16'd1080, 16'd1125, 16'd5, 16'd1080, 1'b0, 1'b0},
    '{32'h0438_0465, 32'h0005_0438, 16'd1080, 16'd1125, 16'd5, 16'd1080, 1'b1, 1'b1},
    '{32'h0438_0465, 32'h0,         16'd1080, 16'd1125, 16'd0, 16'd0,    1'b1, 1'b1},
    '{32'h0438_0465, 32'h0,         16'd1080, 16'd1125, 16'd5, 16'd0,    1'b1, 1'b0},
    '{32'h0, 32'h0, 16'd9, 16'd9, 16'd9, 16'd9, 1'b0, 1'b0},
    '{32'h0, 32'h0, 16'hFFFF, 16'h0, 16'h1234, 16'h1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_sof();
    @(negedge clk);
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic prev;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_act = '0; m_tot = '0; m_frm = '0; m_lin = '0; sof = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 run_en in reset", {31'b0, run_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 run_en after reset", {31'b0, run_en}, 32'd0);
    chk("R1 side enables", {20'b0, pol_auto_en, pad_en, ilace_detect_en, 1'b0, ilace_min_frames}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      chk("R1 register reads zero", v, 32'd0);
    end

    // R3 / R2 side enables and readback
    wr(4'h0, 32'h0003_0018);
    rd(4'h0, v);
    chk("R2 control readback", v, 32'h0003_0018);
    chk("R3 pad_en", {31'b0, pad_en}, 32'd1);
    chk("R3 pol_auto_en", {31'b0, pol_auto_en}, 32'd1);
    chk("R3 ilace_min_frames", {24'b0, ilace_min_frames}, 32'd3);
    chk("R3 ilace_detect_en", {31'b0, ilace_detect_en}, 32'd1);
    wr(4'h0, 32'hFF00_0010);
    chk("R3 ilace off", {31'b0, ilace_detect_en}, 32'd0);
    chk("R3 pad off", {31'b0, pad_en}, 32'd0);
    chk("R10 no run without sof", {31'b0, run_en}, 32'd0);

    // R4 status write ignored
    wr(4'h8, 32'hA5A5_0001);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v);
    chk("R4 status unchanged", v, 32'd0);
    rd(4'h8, v);
    chk("R4 target A unchanged", v, 32'hA5A5_0001);
    rd(4'h0, v);
    chk("R4 control unchanged", v, 32'hFF00_0010);
    chk("R4 run_en unchanged", {31'b0, run_en}, 32'd0);

    // vector table: R5 R6 R7 R8 R9 R10
    prev = 1'b0;
    for (int i = 0; i < NV; i++) begin
      wr(4'h8, VEC[i].tgta);
      wr(4'hC, VEC[i].tgtb);
      wr(4'h0, {31'b0, VEC[i].en});
      m_act = VEC[i].act; m_tot = VEC[i].tot;
      m_frm = VEC[i].frm; m_lin = VEC[i].lin;
      repeat (3) @(negedge clk);
      #1;
      chk($sformatf("R7 hold before sof vec%0d", i), {31'b0, run_en}, {31'b0, prev});
      rd(4'hC, v);
      chk($sformatf("R2 target B readback vec%0d", i), v, VEC[i].tgtb);
      pulse_sof();
      chk($sformatf("R5 R6 R8 R10 run_en vec%0d", i), {31'b0, run_en}, {31'b0, VEC[i].exp_run});
      rd(4'h4, v);
      chk($sformatf("R9 status vec%0d", i), v, {27'b0, VEC[i].exp_run, 4'b0});
      prev = VEC[i].exp_run;
    end

    // R8 stop on clear of enable waits for boundary
    wr(4'h0, 32'h0);
    repeat (5) @(negedge clk);
    #1;
    chk("R8 still running mid-frame", {31'b0, run_en}, 32'd1);
    pulse_sof();
    chk("R8 stopped at boundary", {31'b0, run_en}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule